// File: doc/BRIEF.md
# UART Shutdown Sequencing Controller

This block decides when a serial UART leaves normal operation for its low-power state, and when it comes back. Shutdown has two sources. The first is a software request bit held in the configuration register. The second is an active-low hardware pin.

The two sources act differently:
- **Hardware shutdown** applies on the next clock edge and aborts any frame that is being sent.
- **Software shutdown** is deferred. The controller waits until the transmit holding buffer and the transmit shift register have both gone idle, so every queued character reaches the line first.

On each entry to shutdown, the controller:
- raises a status flag;
- turns off the oscillator enable;
- emits a one-cycle clear pulse. This pulse empties the receive FIFO, clears the receive status and data, and presets the transmit-empty flag.

Return to operation is tied to the host's serial bus. Power-up happens only on a rising edge of chip-select, and only if the software bit reads 0 and the hardware pin is high at that edge. A one-cycle wake pulse then clears every register except the line-control output and the sampled flow-control input.

The block also gates configuration write strobes. Each field that is marked as protected is accepted only while the UART is shut down. Unprotected fields pass through at all times.

Top module: `uart_pwr_seq`

## Requirements
- R1: After reset, `shdn_stat` is 0, `osc_en` is 1, and `tx_abort`, `clr_pulse` and `wake_pulse` are 0.
- R2: When `sw_shdn` is 1, the hardware pin is high and both busy flags are 0, `shdn_stat` becomes 1 after the second clock edge. The first edge enters the drain wait and the second enters shutdown.
- R3: While waiting to drain, `shdn_stat` stays 0 as long as `tx_buf_busy` or `tx_shift_busy` is 1. It becomes 1 after the first edge at which both flags are 0.
- R4: `hw_shdn_n` at 0 in any running or draining state gives `shdn_stat` = 1 after one edge. `tx_abort` is 1 for exactly that first shutdown cycle. A software-only entry never raises `tx_abort`.
- R5: A hardware shutdown that arrives while a software shutdown is waiting to drain takes priority. It enters shutdown after one edge with `tx_abort` = 1, even while the busy flags are 1.
- R6: `clr_pulse` is 1 for exactly one cycle on every entry to shutdown, namely the first cycle in which `shdn_stat` is 1. It is 0 at all other times.
- R7: `osc_en` is always the inverse of `shdn_stat`.
- R8: Shutdown is left only at a rising edge of `cs_n` that is seen while `sw_shdn` is 0 and `hw_shdn_n` is 1. `shdn_stat` falls after the edge that samples `cs_n` high. `wake_pulse` is 1 for exactly that first running cycle.
- R9: A rising edge of `cs_n` while `sw_shdn` is 1 or `hw_shdn_n` is 0 leaves `shdn_stat` at 1 and `wake_pulse` at 0.
- R10: If `sw_shdn` returns to 0 during the drain wait, the block goes back to running without entering shutdown and without a `clr_pulse`.
- R11: The field gating is combinational. `cfg_we_o[i]` equals `cfg_we_i[i]` when bit i of `GATE_MASK` is 0. When that bit is 1, it equals `cfg_we_i[i] & shdn_stat`. The default mask is 8'h7F, which leaves field 7 ungated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_shdn | input | 1 | Software shutdown bit from the configuration register |
| hw_shdn_n | input | 1 | Hardware shutdown pin, active low |
| tx_buf_busy | input | 1 | Transmit holding buffer holds a character |
| tx_shift_busy | input | 1 | Transmit shift register is sending a frame |
| cs_n | input | 1 | Serial host chip-select, active low |
| cfg_we_i | input | NFLD | Per-field configuration write strobes from the host decoder |
| shdn_stat | output | 1 | UART is in shutdown |
| osc_en | output | 1 | Oscillator enable |
| tx_abort | output | 1 | One-cycle pulse that aborts transmission on hardware entry |
| clr_pulse | output | 1 | One-cycle clear of FIFO and status on shutdown entry |
| wake_pulse | output | 1 | One-cycle clear of registers on power-up |
| cfg_we_o | output | NFLD | Gated per-field configuration write strobes |

## Verification
A wrong sequencer state would first show up on `shdn_stat` and `osc_en`. Examples are a drain wait that ignores a busy flag, or a shutdown state that leaves on a chip-select edge when it should not. Either fault shows on the edge right after the triggering input, or as a missing transition two edges after a software request.

A faulty pulse register would show as `clr_pulse`, `tx_abort` or `wake_pulse` being off during the single cycle when the state changes. A faulty gate would pass or drop a strobe at once, with no clock involved.

The drain sweep covers every pair of buffer and shift-register release times up to four cycles. The gating sweep covers all strobe patterns in both power states.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SHDN  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_cs_edge.sv
module pwr_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise
);
  logic cs_q;

  // Reset to high so that releasing reset while chip-select is idle gives no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_rise = cs_n & ~cs_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_shdn,
  input  logic hw_shdn_n,
  input  logic tx_buf_busy,
  input  logic tx_shift_busy,
  input  logic cs_rise,
  output logic shdn_stat,
  output logic osc_en,
  output logic tx_abort,
  output logic clr_pulse,
  output logic wake_pulse
);
  pwr_state_e state_q, state_d;
  logic       osc_q, abort_q, clr_q, wake_q;
  logic       abort_d, clr_d, wake_d;
  logic       tx_idle;

  assign tx_idle = ~tx_buf_busy & ~tx_shift_busy;

  always_comb begin
    state_d = state_q;
    abort_d = 1'b0;
    clr_d   = 1'b0;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (!hw_shdn_n) begin
          state_d = ST_SHDN;
          abort_d = 1'b1;
          clr_d   = 1'b1;
        end else if (sw_shdn) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!hw_shdn_n) begin
          state_d = ST_SHDN;
          abort_d = 1'b1;
          clr_d   = 1'b1;
        end else if (!sw_shdn) begin
          state_d = ST_RUN;
        end else if (tx_idle) begin
          state_d = ST_SHDN;
          clr_d   = 1'b1;
        end
      end
      ST_SHDN: begin
        if (cs_rise && !sw_shdn && hw_shdn_n) begin
          state_d = ST_RUN;
          wake_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      osc_q   <= 1'b1;
      abort_q <= 1'b0;
      clr_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      osc_q   <= (state_d != ST_SHDN);
      abort_q <= abort_d;
      clr_q   <= clr_d;
      wake_q  <= wake_d;
    end
  end

  assign shdn_stat  = (state_q == ST_SHDN);
  assign osc_en     = osc_q;
  assign tx_abort   = abort_q;
  assign clr_pulse  = clr_q;
  assign wake_pulse = wake_q;

  // R3: no shutdown while software drain still has traffic in flight
  p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && hw_shdn_n && !tx_idle) |=> !shdn_stat);

  // R4: hardware pin low forces shutdown with an abort on the next edge
  p_hw_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_stat && !hw_shdn_n) |=> (shdn_stat && tx_abort));

  // R4: software drain completion never aborts
  p_sw_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && hw_shdn_n) |=> !tx_abort);

  // R6: clear pulse marks exactly the first shutdown cycle
  p_clr_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse == (shdn_stat && !$past(shdn_stat)));

  // R7: oscillator enable opposes shutdown status
  p_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en != shdn_stat);

  // R8: leaving shutdown requires a chip-select rise in the previous cycle
  p_exit_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_stat) |-> ($past(cs_rise) && wake_pulse));
endmodule

// File: rtl/pwr_cfg_gate.sv
module pwr_cfg_gate #(
  parameter int             NFLD      = 8,
  parameter logic [NFLD-1:0] GATE_MASK = 8'h7F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shdn_stat,
  input  logic [NFLD-1:0] we_i,
  output logic [NFLD-1:0] we_o
);
  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    if (GATE_MASK[g]) begin : g_locked
      assign we_o[g] = we_i[g] & shdn_stat;
    end else begin : g_open
      assign we_o[g] = we_i[g];
    end
  end

  // R11: protected fields are never strobed while running
  p_gate_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_stat |-> ((we_o & GATE_MASK) == '0));
endmodule

// File: rtl/uart_pwr_seq.sv
module uart_pwr_seq #(
  parameter int              NFLD      = 8,
  parameter logic [NFLD-1:0] GATE_MASK = 8'h7F,
  parameter int              RST_STG   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_shdn,
  input  logic            hw_shdn_n,
  input  logic            tx_buf_busy,
  input  logic            tx_shift_busy,
  input  logic            cs_n,
  input  logic [NFLD-1:0] cfg_we_i,
  output logic            shdn_stat,
  output logic            osc_en,
  output logic            tx_abort,
  output logic            clr_pulse,
  output logic            wake_pulse,
  output logic [NFLD-1:0] cfg_we_o
);
  logic rst_sync_n;
  logic cs_rise;

  pwr_rst_sync #(.STAGES(RST_STG)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwr_cs_edge i_cs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise)
  );

  pwr_seq_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .sw_shdn       (sw_shdn),
    .hw_shdn_n     (hw_shdn_n),
    .tx_buf_busy   (tx_buf_busy),
    .tx_shift_busy (tx_shift_busy),
    .cs_rise       (cs_rise),
    .shdn_stat     (shdn_stat),
    .osc_en        (osc_en),
    .tx_abort      (tx_abort),
    .clr_pulse     (clr_pulse),
    .wake_pulse    (wake_pulse)
  );

  pwr_cfg_gate #(.NFLD(NFLD), .GATE_MASK(GATE_MASK)) i_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shdn_stat (shdn_stat),
    .we_i      (cfg_we_i),
    .we_o      (cfg_we_o)
  );
endmodule

// File: tb/test_uart_pwr_seq.sv
module test_uart_pwr_seq;
  localparam int         NFLD = 8;
  localparam logic [7:0] MASK = 8'h7F;

  logic clk = 1'b0;
  logic rst_n, sw_shdn, hw_shdn_n, tx_buf_busy, tx_shift_busy, cs_n;
  logic [NFLD-1:0] cfg_we_i, cfg_we_o;
  logic shdn_stat, osc_en, tx_abort, clr_pulse, wake_pulse;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uart_pwr_seq #(.NFLD(NFLD), .GATE_MASK(MASK)) i_uart_pwr_seq (
    .clk(clk), .rst_n(rst_n), .sw_shdn(sw_shdn), .hw_shdn_n(hw_shdn_n),
    .tx_buf_busy(tx_buf_busy), .tx_shift_busy(tx_shift_busy), .cs_n(cs_n),
    .cfg_we_i(cfg_we_i), .shdn_stat(shdn_stat), .osc_en(osc_en),
    .tx_abort(tx_abort), .clr_pulse(clr_pulse), .wake_pulse(wake_pulse),
    .cfg_we_o(cfg_we_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Shutdown status, oscillator and the three pulses as one word.
  task automatic chk_out(input string req, input logic s, input logic ab,
                         input logic cl, input logic wk);
    chk(req, {27'd0, shdn_stat, osc_en, tx_abort, clr_pulse, wake_pulse},
        {27'd0, s, ~s, ab, cl, wk});
  endtask

  task automatic cs_pulse();
    cs_n = 1'b0; step();
    cs_n = 1'b1; step();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw_shdn = 1'b0; hw_shdn_n = 1'b1;
    tx_buf_busy = 1'b0; tx_shift_busy = 1'b0; cs_n = 1'b1; cfg_we_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk_out("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);

    // R2/R3/R6: sweep buffer release b and shift release s; busy before edge e is e<=b / e<=s
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 4; s++) begin
        int ent;
        ent = ((b > s ? b : s) + 1 < 2) ? 2 : (b > s ? b : s) + 1;
        sw_shdn = 1'b1;
        for (int e = 1; e <= 6; e++) begin
          tx_buf_busy   = (e <= b);
          tx_shift_busy = (e <= s);
          step();
          chk((b == 0 && s == 0) ? "R2 sw entry" : "R3 drain wait",
              {27'd0, shdn_stat, osc_en, tx_abort, clr_pulse, wake_pulse},
              {27'd0, (e >= ent), ~(e >= ent), 1'b0, (e == ent), 1'b0});
        end
        tx_buf_busy = 1'b0; tx_shift_busy = 1'b0;
        sw_shdn = 1'b0;
        cs_n = 1'b0; step();
        chk_out("R8 no exit before cs rise", 1'b1, 1'b0, 1'b0, 1'b0);
        cs_n = 1'b1; step();
        chk_out("R8 exit on cs rise", 1'b0, 1'b0, 1'b0, 1'b1);
        step();
        chk_out("R8 wake pulse one cycle", 1'b0, 1'b0, 1'b0, 1'b0);
      end
    end

    // R4: hardware entry from running
    tx_shift_busy = 1'b1;
    hw_shdn_n = 1'b0; step();
    chk_out("R4 hw entry abort", 1'b1, 1'b1, 1'b1, 1'b0);
    step();
    chk_out("R6 pulses one cycle", 1'b1, 1'b0, 1'b0, 1'b0);
    tx_shift_busy = 1'b0;
    cs_pulse();
    chk_out("R9 cs rise with pin low", 1'b1, 1'b0, 1'b0, 1'b0);
    hw_shdn_n = 1'b1; sw_shdn = 1'b1;
    cs_pulse();
    chk_out("R9 cs rise with sw set", 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    chk_out("R9 still down", 1'b1, 1'b0, 1'b0, 1'b0);
    sw_shdn = 1'b0;
    step();
    chk_out("R8 sw clear alone no exit", 1'b1, 1'b0, 1'b0, 1'b0);
    cs_n = 1'b0; step(); cs_n = 1'b1; step();
    chk_out("R8 exit", 1'b0, 1'b0, 1'b0, 1'b1);

    // R11: full sweep of strobes while running
    for (int v = 0; v < 256; v++) begin
      cfg_we_i = v[7:0]; #1;
      chk("R11 gate run", {24'd0, cfg_we_o}, {24'd0, v[7:0] & ~MASK});
    end
    cfg_we_i = '0;

    // R5: hardware during software drain with traffic pending
    sw_shdn = 1'b1; tx_buf_busy = 1'b1; tx_shift_busy = 1'b1;
    step(); step();
    chk_out("R3 held in drain", 1'b0, 1'b0, 1'b0, 1'b0);
    hw_shdn_n = 1'b0; step();
    chk_out("R5 hw overrides drain", 1'b1, 1'b1, 1'b1, 1'b0);
    hw_shdn_n = 1'b1; tx_buf_busy = 1'b0; tx_shift_busy = 1'b0;

    // R11: full sweep of strobes while shut down
    for (int v = 0; v < 256; v++) begin
      cfg_we_i = v[7:0]; #1;
      chk("R11 gate shdn", {24'd0, cfg_we_o}, {24'd0, v[7:0]});
    end
    cfg_we_i = '0;
    sw_shdn = 1'b0;
    cs_pulse();
    chk_out("R8 exit after hw", 1'b0, 1'b0, 1'b0, 1'b1);

    // R10: software request withdrawn during drain
    sw_shdn = 1'b1; tx_shift_busy = 1'b1;
    step(); step();
    sw_shdn = 1'b0; step();
    chk_out("R10 back to run", 1'b0, 1'b0, 1'b0, 1'b0);
    tx_shift_busy = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk_out("R10 no entry", 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R1 again: reset in shutdown returns to running
    hw_shdn_n = 1'b0; step();
    hw_shdn_n = 1'b1;
    rst_n = 1'b0; #1;
    chk_out("R1 async reset", 1'b0, 1'b0, 1'b0, 1'b0);
    step(); rst_n = 1'b1; repeat (3) step();
    chk_out("R1 after release", 1'b0, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule